// File: doc/BRIEF.md
# Two-Wire Serial Memory Slave

This block is the slave side of a byte-addressed memory that sits on a two-wire serial bus. It watches the clock and data lines for start and stop conditions, shifts in bytes on clock rising edges, and answers each accepted byte with an acknowledge. It pulls the data line low through an open-drain output enable. The first byte after a start selects the device and the direction of the transfer. It matches only if its upper nibble carries the fixed device-type code and its next three bits equal the strapped select inputs. Up to eight such slaves can therefore share one bus.

A write carries two word-address bytes and then data bytes. Together the two address bytes load a 13-bit address counter: the high byte supplies the page's upper bits, and the low byte supplies the lower page bits and the 5-bit offset in the 32-byte page. A read takes its address from the counter, and the counter keeps its value across stops and repeated starts. A random read is therefore an address-only write, a repeated start and a read. The storage is an internal byte array, indexed by the low `MEM_AW` bits of the counter.

The bus pins are plain control signals, with no valid/ready framing. Flow control is the bus's own: the acknowledge bit that the master drives during a read decides whether another byte follows, and the slave never stretches the clock.

Top module: `tws_mem_slave`

## Requirements
- R1: After a start, the first byte (MSB first) is accepted only when bits 7..4 equal 4'b1010 and bits 3..1 equal `sel_i`; bit 0 selects read (1) or write (0). An accepted byte is acknowledged by asserting `sda_oe_o` throughout the ninth SCL high phase.
- R2: A device byte with a wrong type code or wrong select bits gets no acknowledge. The block then ignores the bus until the next start, and bytes sent in between neither are acknowledged nor change the array.
- R3: On a write, the two bytes after the device byte load the counter. Bits 4..0 of the first byte become A12..A8 and its bits 7..5 are ignored. The second byte becomes A7..A0. Both bytes are acknowledged.
- R4: Each further written byte is stored at the counter address and acknowledged, and the counter then increments by one.
- R5: A read returns the byte at the counter, MSB first, with `sda_oe_o` asserted exactly for zero bits. The counter increments after every byte. Reading continues while the master drives SDA low in the ninth clock; on a high there (NACK) the block releases SDA and goes idle.
- R6: A repeated start after the two address bytes of a write, followed by a read device byte, reads from the address just loaded.
- R7: A stop ends any transfer and releases SDA. The counter keeps its value, so a read without address bytes after a stop continues where the last access ended.
- R8: `sda_oe_o` is low while the master sends data bits, and it changes only on SCL falling edges or on start/stop conditions, never during an SCL high phase.
- R9: After reset `sda_oe_o` is low and the counter is 0, so a read without address bytes starts at address 0. The array contents are not cleared.
- R10: The counter wraps from 13'h1FFF to 0. A byte at address A is stored at array entry A mod 2^MEM_AW.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, samples the bus lines |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Synchronized bus clock level |
| sda_i | input | 1 | Synchronized bus data level (wired-AND of all drivers) |
| sel_i | input | 3 | Strapped device-select value |
| sda_oe_o | output | 1 | 1 pulls SDA low; 0 releases it |

## Verification
The assertions assume that SCL and SDA are already synchronized to `clk`. They also assume that SDA changes only while SCL is low, except for the master's start and stop conditions. `sel_i` must stay static while a transfer is in progress, and every bus level must last at least a couple of system clocks. The stimulus keeps within these limits. It builds every transfer from bit phases of several clocks each. It changes data only after SCL has fallen, and it holds the select inputs at one value for the whole run, so a device-select mismatch comes only from the byte that is sent.

// File: rtl/tws_pkg.sv
package tws_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DEV,
    ST_AHI,
    ST_ALO,
    ST_WDAT,
    ST_RDAT
  } tws_state_e;

  localparam logic [3:0] DEV_TYPE = 4'b1010;
  localparam int         BYTE_W   = 8;
  localparam int         ACK_SLOT = BYTE_W;
  localparam int         END_SLOT = BYTE_W + 1;
endpackage

// File: rtl/tws_bus_events.sv
module tws_bus_events (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
    end
  end

  assign scl_rise  = !scl_q && scl_i;
  assign scl_fall  = scl_q && !scl_i;
  assign start_det = scl_q && scl_i && sda_q && !sda_i;
  assign stop_det  = scl_q && scl_i && !sda_q && sda_i;
endmodule

// File: rtl/tws_addr_ctr.sv
module tws_addr_ctr #(
  parameter int ADDR_W = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_hi,
  input  logic              ld_lo,
  input  logic              inc,
  input  logic [7:0]        byte_i,
  output logic [ADDR_W-1:0] addr_o
);
  localparam int HI_W = ADDR_W - 8;

  logic [HI_W-1:0]   hi_q;
  logic [ADDR_W-1:0] addr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q   <= '0;
      addr_q <= '0;
    end else begin
      if (ld_hi) hi_q <= byte_i[HI_W-1:0];
      if (ld_lo) addr_q <= {hi_q, byte_i};
      else if (inc) addr_q <= addr_q + 1'b1;
    end
  end

  assign addr_o = addr_q;

  a_r4_counter_step: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && !ld_lo) |=> (addr_o == $past(addr_o) + 1'b1));

  a_r7_counter_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!inc && !ld_lo) |=> $stable(addr_o));
endmodule

// File: rtl/tws_mem.sv
module tws_mem #(
  parameter int MEM_AW = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [MEM_AW-1:0] waddr,
  input  logic [7:0]        wdata,
  input  logic [MEM_AW-1:0] raddr,
  output logic [7:0]        rdata
);
  localparam int DEPTH = 1 << MEM_AW;

  logic [7:0] mem_q [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem_q[waddr] <= wdata;
  end

  assign rdata = mem_q[raddr];

  a_r4_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> (mem_q[$past(waddr)] == $past(wdata)));
endmodule

// File: rtl/tws_mem_slave.sv
module tws_mem_slave
  import tws_pkg::*;
#(
  parameter int ADDR_W = 13,
  parameter int MEM_AW = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic [2:0] sel_i,
  output logic       sda_oe_o
);
  localparam int CNT_W = $clog2(END_SLOT + 1);

  logic scl_rise, scl_fall, start_det, stop_det;
  tws_state_e st_q;
  logic [CNT_W-1:0] cnt_q;
  logic [7:0] sr_q, rd_sr_q, rdata;
  logic drv_q, mack_q;
  logic [ADDR_W-1:0] addr;
  logic byte_done, slot_end, dev_match, ld_hi, ld_lo, inc, we;

  tws_bus_events u_ev (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  assign byte_done = scl_fall && !start_det && !stop_det && (st_q != ST_IDLE)
                     && (cnt_q == CNT_W'(ACK_SLOT));
  assign slot_end  = scl_fall && !start_det && !stop_det && (st_q != ST_IDLE)
                     && (cnt_q == CNT_W'(END_SLOT));
  assign dev_match = (sr_q[7:4] == DEV_TYPE) && (sr_q[3:1] == sel_i);
  assign ld_hi     = byte_done && (st_q == ST_AHI);
  assign ld_lo     = byte_done && (st_q == ST_ALO);
  assign we        = byte_done && (st_q == ST_WDAT);
  assign inc       = byte_done && ((st_q == ST_WDAT) || (st_q == ST_RDAT));

  tws_addr_ctr #(.ADDR_W(ADDR_W)) u_ctr (
    .clk(clk), .rst_n(rst_n), .ld_hi(ld_hi), .ld_lo(ld_lo), .inc(inc),
    .byte_i(sr_q), .addr_o(addr)
  );

  tws_mem #(.MEM_AW(MEM_AW)) u_mem (
    .clk(clk), .rst_n(rst_n), .we(we), .waddr(addr[MEM_AW-1:0]),
    .wdata(sr_q), .raddr(addr[MEM_AW-1:0]), .rdata(rdata)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      cnt_q   <= '0;
      sr_q    <= '0;
      rd_sr_q <= '0;
      drv_q   <= 1'b0;
      mack_q  <= 1'b0;
    end else if (start_det) begin
      st_q  <= ST_DEV;
      cnt_q <= '0;
      drv_q <= 1'b0;
    end else if (stop_det) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
      drv_q <= 1'b0;
    end else if (st_q != ST_IDLE) begin
      if (scl_rise) begin
        if (cnt_q < CNT_W'(ACK_SLOT)) sr_q <= {sr_q[6:0], sda_i};
        if (cnt_q == CNT_W'(ACK_SLOT)) mack_q <= !sda_i;
        if (cnt_q < CNT_W'(END_SLOT)) cnt_q <= cnt_q + 1'b1;
      end
      if (byte_done) begin
        unique case (st_q)
          ST_DEV: begin
            if (dev_match) drv_q <= 1'b1;
            else begin
              st_q  <= ST_IDLE;
              cnt_q <= '0;
              drv_q <= 1'b0;
            end
          end
          ST_RDAT: drv_q <= 1'b0;
          default: drv_q <= 1'b1;
        endcase
      end else if (slot_end) begin
        cnt_q <= '0;
        unique case (st_q)
          ST_DEV: begin
            if (sr_q[0]) begin
              st_q    <= ST_RDAT;
              rd_sr_q <= rdata;
              drv_q   <= !rdata[7];
            end else begin
              st_q  <= ST_AHI;
              drv_q <= 1'b0;
            end
          end
          ST_AHI: begin
            st_q  <= ST_ALO;
            drv_q <= 1'b0;
          end
          ST_ALO: begin
            st_q  <= ST_WDAT;
            drv_q <= 1'b0;
          end
          ST_RDAT: begin
            if (mack_q) begin
              rd_sr_q <= rdata;
              drv_q   <= !rdata[7];
            end else begin
              st_q  <= ST_IDLE;
              drv_q <= 1'b0;
            end
          end
          default: drv_q <= 1'b0;
        endcase
      end else if (scl_fall && (st_q == ST_RDAT) && (cnt_q != '0)
                   && (cnt_q < CNT_W'(ACK_SLOT))) begin
        rd_sr_q <= {rd_sr_q[6:0], 1'b0};
        drv_q   <= !rd_sr_q[6];
      end
    end
  end

  assign sda_oe_o = drv_q;

  a_r2_quiet_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_IDLE) |-> !sda_oe_o);

  a_r1_ack_needs_match: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_DEV && drv_q) |-> ((sr_q[7:4] == DEV_TYPE) && (sr_q[3:1] == sel_i)));

  a_r7_stop_releases: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> (!sda_oe_o && st_q == ST_IDLE));

  a_r8_steady_in_scl_high: assert property (@(posedge clk) disable iff (!rst_n)
    (!scl_rise && !scl_fall && !start_det && !stop_det) |=> $stable(sda_oe_o));
endmodule

// File: tb/tws_mem_slave_bench.sv
`timescale 1ns/1ps
module tws_mem_slave_bench;
  localparam int Q = 4;
  localparam logic [2:0] SEL = 3'b101;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1;
  logic sda_m = 1'b1;
  logic sda_oe;
  logic sda_bus;
  int checks = 0;
  int fails = 0;
  logic [7:0] model [256];
  logic [7:0] wbuf [4];

  always #2.5 clk = ~clk;
  assign sda_bus = sda_m & ~sda_oe;

  tws_mem_slave u_tws_mem_slave (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_bus),
    .sel_i(SEL), .sda_oe_o(sda_oe)
  );

  function automatic logic [7:0] dev_byte(input logic rd);
    return {4'b1010, SEL, rd};
  endfunction

  function automatic logic [7:0] exp_byte(input logic [12:0] a);
    return model[a[7:0]];
  endfunction

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic w(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start;
    sda_m = 1'b1; w(Q); scl = 1'b1; w(Q);
    sda_m = 1'b0; w(Q); scl = 1'b0; w(Q);
  endtask

  task automatic bus_stop;
    sda_m = 1'b0; w(Q); scl = 1'b1; w(Q); sda_m = 1'b1; w(Q);
  endtask

  task automatic send(input logic [7:0] b, input logic exp_ack, input string req);
    logic drove;
    logic ack;
    drove = 1'b0;
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; w(Q);
      scl = 1'b1; w(Q / 2);
      drove |= sda_oe; w(Q / 2);
      scl = 1'b0; w(Q);
    end
    chk(!drove, "R8 release during master bits", int'(drove), 0);
    sda_m = 1'b1; w(Q);
    scl = 1'b1; w(Q / 2);
    ack = sda_oe; w(Q / 2);
    scl = 1'b0; w(Q);
    chk(ack == exp_ack, req, int'(ack), int'(exp_ack));
  endtask

  task automatic recv(input logic mack, input logic [7:0] exp, input string req);
    logic [7:0] got;
    logic steady;
    steady = 1'b1;
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      w(Q);
      scl = 1'b1; w(1);
      got[i] = sda_bus; w(Q - 2);
      steady &= (sda_bus == got[i]); w(1);
      scl = 1'b0;
    end
    chk(got == exp, req, int'(got), int'(exp));
    chk(steady, "R8 data steady while SCL high", int'(steady), 1);
    w(Q);
    sda_m = !mack; w(Q);
    scl = 1'b1; w(Q);
    scl = 1'b0; w(Q);
    sda_m = 1'b1;
  endtask

  task automatic do_write(input logic [12:0] a, input int n, input logic [2:0] junk);
    bus_start;
    send(dev_byte(1'b0), 1'b1, "R1 write device ack");
    send({junk, a[12:8]}, 1'b1, "R3 high address ack");
    send(a[7:0], 1'b1, "R3 low address ack");
    for (int i = 0; i < n; i++) begin
      logic [12:0] ai;
      ai = a + 13'(i);
      send(wbuf[i], 1'b1, "R4 data ack");
      model[ai[7:0]] = wbuf[i];
    end
    bus_stop;
  endtask

  task automatic do_rread(input logic [12:0] a, input int n, input string req);
    bus_start;
    send(dev_byte(1'b0), 1'b1, "R1 device ack");
    send({3'b000, a[12:8]}, 1'b1, "R3 high address ack");
    send(a[7:0], 1'b1, "R3 low address ack");
    bus_start;
    send(dev_byte(1'b1), 1'b1, "R6 read device ack after repeated start");
    for (int i = 0; i < n; i++) recv(i < n - 1, exp_byte(a + 13'(i)), req);
    chk(sda_oe == 1'b0, "R5 released after NACK", int'(sda_oe), 0);
    bus_stop;
  endtask

  task automatic do_cread(input logic [12:0] a, input int n, input string req);
    bus_start;
    send(dev_byte(1'b1), 1'b1, "R1 read device ack");
    for (int i = 0; i < n; i++) recv(i < n - 1, exp_byte(a + 13'(i)), req);
    bus_stop;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd7321));
    w(5);
    chk(sda_oe == 1'b0, "R9 released in reset", int'(sda_oe), 0);
    rst_n = 1'b1;
    w(5);
    chk(sda_oe == 1'b0, "R9 released after reset", int'(sda_oe), 0);

    // R3 / R4: directed write with junk in the ignored high bits
    wbuf[0] = 8'h11; wbuf[1] = 8'h22; wbuf[2] = 8'h33; wbuf[3] = 8'h44;
    do_write(13'h0123, 4, 3'b111);
    do_rread(13'h0123, 2, "R5 sequential read");
    // R7: counter survives the stop
    do_cread(13'h0125, 2, "R7 read continues after stop");

    // R2: wrong type code, then wrong select, then the protected byte is unchanged
    wbuf[0] = 8'hA5;
    do_write(13'h0050, 1, 3'b000);
    bus_start;
    send({4'b1011, SEL, 1'b0}, 1'b0, "R2 no ack for wrong type");
    send(8'h00, 1'b0, "R2 ignored byte");
    send(8'h50, 1'b0, "R2 ignored byte");
    send(8'h3C, 1'b0, "R2 ignored byte");
    bus_stop;
    bus_start;
    send({4'b1010, ~SEL, 1'b0}, 1'b0, "R2 no ack for wrong select");
    send(8'h00, 1'b0, "R2 ignored byte");
    send(8'h50, 1'b0, "R2 ignored byte");
    send(8'h3C, 1'b0, "R2 ignored byte");
    bus_stop;
    do_rread(13'h0050, 1, "R2 array untouched");

    // R10: wrap of the counter
    wbuf[0] = 8'h5A; wbuf[1] = 8'hC3;
    do_write(13'h1FFF, 2, 3'b010);
    do_rread(13'h1FFF, 2, "R10 wrap read");

    // random writes and random reads
    for (int k = 0; k < 12; k++) begin
      logic [12:0] a;
      int n;
      a = 13'($urandom);
      n = 1 + int'($urandom % 4);
      for (int i = 0; i < 4; i++) wbuf[i] = 8'($urandom);
      do_write(a, n, 3'($urandom));
      do_rread(a, n, "R4 random write then R5 read");
    end

    // R9: counter back to 0 after reset, array kept
    rst_n = 1'b0; w(3); rst_n = 1'b1; w(3);
    do_cread(13'h0000, 1, "R9 counter zero after reset");

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule